// File: doc/BRIEF.md
# Three-Wire Up/Down Potentiometer Host Sequencer

This block acts as the host side of a digitally stepped potentiometer that is controlled through three wires: an active-low select, a direction level and an active-low increment strobe. Each strobe falling edge moves the remote wiper by one tap. A command arrives over a valid/ready handshake. It carries a signed step count and a commit flag. A positive or zero count moves the wiper up and a negative count moves it down. When the commit flag is set, the wiper position is written to the remote device's nonvolatile cell as the sequence ends.

Every minimum interval of the wire protocol is a parameter given in nanoseconds. Each interval is turned into clock cycles from a clock-period parameter and rounded up. The interval limits are the select-to-strobe setup, the direction setup and hold, the strobe low and high widths, the strobe period, the gap from the last strobe to deselect, and the two deselect recovery times. The strobe level at the moment of deselect selects the ending. A high strobe commits the position. A low strobe leaves the stored value untouched. After a committing ending the block refuses new commands until the long store time has passed.

Top module: `pot_step_seq`

## Requirements
- R1: Out of reset and while idle, `pot_cs_n` and `pot_inc_n` are both 1 and `cmd_ready` is 1.
- R2: A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is 0 whenever the select is active. A command with zero steps and `cmd_store`=0 is taken without any pin moving, and `cmd_ready` stays 1.
- R3: `pot_ud` is set to 1 for a step count of zero or more and to 0 for a negative count, in the cycle the command is taken. The number of strobe falling edges equals the magnitude of the count, including the most negative value.
- R4: The first strobe falling edge comes exactly SETUP cycles after the select falls, where SETUP is the larger of the select setup and the direction setup. Every falling edge is at least the direction setup time after the last change of `pot_ud`.
- R5: Strobe falling edges happen only while the select is active. Each low phase lasts at least the low width. Between steps, each high phase lasts at least the larger of the high width and (period minus low width).
- R6: With `cmd_store`=1 the select is released while the strobe is high. This happens exactly TAIL cycles after the last strobe rising edge, where TAIL is the larger of the strobe-to-deselect gap and the high width.
- R7: With `cmd_store`=0 the strobe is held low across the deselect. The deselect comes exactly the larger of the low width and the strobe-to-deselect gap after the last falling edge. The strobe returns high exactly the no-store hold time after the deselect.
- R8: `cmd_ready` returns exactly STORE cycles after a committing deselect. After a non-committing deselect it returns exactly the no-store hold time plus the direction hold time after the deselect.
- R9: A command with zero steps and `cmd_store`=1 selects the device, makes no strobe edge, and deselects with the strobe high (a commit) SETUP+TAIL cycles after selecting.
- R10: `pot_ud` changes only while the select and the strobe are both inactive, and at least the direction hold time after the last strobe rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_steps | input | STEP_W | Signed step count; sign gives direction |
| cmd_store | input | 1 | 1 = commit the final position to nonvolatile storage |
| pot_cs_n | output | 1 | Active-low device select |
| pot_ud | output | 1 | Direction level, 1 = up |
| pot_inc_n | output | 1 | Active-low step strobe, steps on falling edge |

## Verification
The select falls on the clock edge that takes the command, and so does the direction change. Every later pin change is a whole number of phase lengths after that edge, because each phase is one registered timer load. The bench therefore predicts exact cycle offsets. First strobe = accept + SETUP. Deselect = last rising edge + TAIL, or last falling edge + the no-store low length. Ready = deselect + STORE, or deselect + hold + rearm. A monitor samples the pins at the falling clock edge and timestamps each transition with the cycle count of the preceding rising edge. Each stamp is compared with either the exact offset or the minimum interval. A device model counts taps and stored values so that step counts and commits can be checked at the end of each scenario.

// File: rtl/pot_seq_pkg.sv
package pot_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOW,
        ST_HIGH,
        ST_TAIL,
        ST_HOLD,
        ST_REARM
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ud;
        logic inc_n;
    } pot_pins_t;

    localparam pot_pins_t PINS_IDLE = '{cs_n: 1'b1, ud: 1'b1, inc_n: 1'b1};

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input longint ns, input longint clk_ps);
        longint c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c < 1) c = 1;
        return int'(c);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pot_seq_timer.sv
module pot_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // A load of N makes done rise N cycles later.
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pot_seq_steps.sv
module pot_seq_steps #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [STEP_W-1:0] steps,
    input  logic              dec,
    output logic              rem_zero,
    output logic              rem_one
);
    logic [STEP_W-1:0] rem;
    logic [STEP_W-1:0] mag;

    // Two's complement magnitude; the most negative code maps to 2**(STEP_W-1).
    always_comb mag = steps[STEP_W-1] ? (~steps + 1'b1) : steps;

    always_ff @(posedge clk) begin
        if (rst)
            rem <= '0;
        else if (load)
            rem <= mag;
        else if (dec && rem != '0)
            rem <= rem - 1'b1;
    end

    assign rem_zero = (rem == '0);
    assign rem_one  = (rem == STEP_W'(1));
endmodule

// File: rtl/pot_seq_ctrl.sv
module pot_seq_ctrl
    import pot_seq_pkg::*;
#(
    parameter int STEP_W      = 6,
    parameter int TMR_W       = 8,
    parameter int SETUP_CYC   = 1,
    parameter int LOW_CYC     = 1,
    parameter int LOWEND_CYC  = 1,
    parameter int HIGH_CYC    = 1,
    parameter int TAIL_CYC    = 1,
    parameter int STORE_CYC   = 1,
    parameter int NOSTORE_CYC = 1,
    parameter int REARM_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_store,
    input  logic              t_done,
    input  logic              rem_zero,
    input  logic              rem_one,
    output logic              cmd_ready,
    output pot_pins_t         pins,
    output logic              t_load,
    output logic [TMR_W-1:0]  t_val,
    output logic              s_load,
    output logic              s_dec
);
    localparam logic [TMR_W-1:0] V_SETUP   = TMR_W'(SETUP_CYC);
    localparam logic [TMR_W-1:0] V_LOW     = TMR_W'(LOW_CYC);
    localparam logic [TMR_W-1:0] V_LOWEND  = TMR_W'(LOWEND_CYC);
    localparam logic [TMR_W-1:0] V_HIGH    = TMR_W'(HIGH_CYC);
    localparam logic [TMR_W-1:0] V_TAIL    = TMR_W'(TAIL_CYC);
    localparam logic [TMR_W-1:0] V_STORE   = TMR_W'(STORE_CYC);
    localparam logic [TMR_W-1:0] V_NOSTORE = TMR_W'(NOSTORE_CYC);
    localparam logic [TMR_W-1:0] V_REARM   = TMR_W'(REARM_CYC);

    seq_state_t state, nxt_state;
    pot_pins_t  nxt_pins;
    logic       store_q, nxt_store;

    always_comb begin
        nxt_state = state;
        nxt_pins  = pins;
        nxt_store = store_q;
        t_load    = 1'b0;
        t_val     = '0;
        s_load    = 1'b0;
        s_dec     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid && (cmd_steps != '0 || cmd_store)) begin
                    nxt_state     = ST_SETUP;
                    nxt_pins.cs_n = 1'b0;
                    nxt_pins.ud   = ~cmd_steps[STEP_W-1];
                    nxt_store     = cmd_store;
                    t_load        = 1'b1;
                    t_val         = V_SETUP;
                    s_load        = 1'b1;
                end
            end
            ST_SETUP: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (rem_zero) begin
                        nxt_state = ST_TAIL;
                        t_val     = V_TAIL;
                    end else begin
                        nxt_state      = ST_LOW;
                        nxt_pins.inc_n = 1'b0;
                        s_dec          = 1'b1;
                        t_val          = (rem_one && !store_q) ? V_LOWEND : V_LOW;
                    end
                end
            end
            ST_LOW: begin
                if (t_done) begin
                    t_load = 1'b1;
                    if (rem_zero && !store_q) begin
                        nxt_state     = ST_HOLD;
                        nxt_pins.cs_n = 1'b1;
                        t_val         = V_NOSTORE;
                    end else begin
                        nxt_pins.inc_n = 1'b1;
                        nxt_state      = rem_zero ? ST_TAIL : ST_HIGH;
                        t_val          = rem_zero ? V_TAIL : V_HIGH;
                    end
                end
            end
            ST_HIGH: begin
                if (t_done) begin
                    nxt_state      = ST_LOW;
                    nxt_pins.inc_n = 1'b0;
                    s_dec          = 1'b1;
                    t_load         = 1'b1;
                    t_val          = (rem_one && !store_q) ? V_LOWEND : V_LOW;
                end
            end
            ST_TAIL: begin
                if (t_done) begin
                    nxt_state     = ST_HOLD;
                    nxt_pins.cs_n = 1'b1;
                    t_load        = 1'b1;
                    t_val         = V_STORE;
                end
            end
            ST_HOLD: begin
                if (t_done) begin
                    if (!pins.inc_n) begin
                        nxt_state      = ST_REARM;
                        nxt_pins.inc_n = 1'b1;
                        t_load         = 1'b1;
                        t_val          = V_REARM;
                    end else begin
                        nxt_state = ST_IDLE;
                    end
                end
            end
            ST_REARM: begin
                if (t_done) nxt_state = ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            pins    <= PINS_IDLE;
            store_q <= 1'b0;
        end else begin
            state   <= nxt_state;
            pins    <= nxt_pins;
            store_q <= nxt_store;
        end
    end

    assign cmd_ready = (state == ST_IDLE);
endmodule

// File: rtl/pot_step_seq.sv
module pot_step_seq
    import pot_seq_pkg::*;
#(
    parameter int CLK_PS       = 10000,
    parameter int STEP_W       = 6,
    parameter int CS_SETUP_NS  = 100,
    parameter int UD_SETUP_NS  = 2900,
    parameter int UD_HOLD_NS   = 100,
    parameter int INC_LOW_NS   = 1000,
    parameter int INC_HIGH_NS  = 1000,
    parameter int INC_CYC_NS   = 2000,
    parameter int INC_CS_NS    = 1000,
    parameter int STORE_NS     = 20000000,
    parameter int NOSTORE_NS   = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [STEP_W-1:0] cmd_steps,
    input  logic              cmd_store,
    output logic              pot_cs_n,
    output logic              pot_ud,
    output logic              pot_inc_n
);
    localparam int SETUP_CYC   = max_int(ns_to_cyc(CS_SETUP_NS, CLK_PS),
                                         ns_to_cyc(UD_SETUP_NS, CLK_PS));
    localparam int LOW_CYC     = ns_to_cyc(INC_LOW_NS, CLK_PS);
    localparam int CS_GAP_CYC  = ns_to_cyc(INC_CS_NS, CLK_PS);
    localparam int LOWEND_CYC  = max_int(LOW_CYC, CS_GAP_CYC);
    localparam int HIGH_CYC    = max_int(ns_to_cyc(INC_HIGH_NS, CLK_PS),
                                         ns_to_cyc(INC_CYC_NS, CLK_PS) - LOW_CYC);
    localparam int TAIL_CYC    = max_int(CS_GAP_CYC, ns_to_cyc(INC_HIGH_NS, CLK_PS));
    localparam int STORE_CYC   = ns_to_cyc(STORE_NS, CLK_PS);
    localparam int NOSTORE_CYC = ns_to_cyc(NOSTORE_NS, CLK_PS);
    localparam int REARM_CYC   = ns_to_cyc(UD_HOLD_NS, CLK_PS);
    localparam int MAX_CYC     = max_int(max_int(max_int(SETUP_CYC, LOWEND_CYC),
                                                 max_int(HIGH_CYC, TAIL_CYC)),
                                         max_int(max_int(STORE_CYC, NOSTORE_CYC),
                                                 REARM_CYC));
    localparam int TMR_W       = $clog2(MAX_CYC + 1);

    pot_pins_t        pins;
    logic             t_load, t_done, s_load, s_dec, rem_zero, rem_one;
    logic [TMR_W-1:0] t_val;

    pot_seq_ctrl #(
        .STEP_W(STEP_W), .TMR_W(TMR_W), .SETUP_CYC(SETUP_CYC), .LOW_CYC(LOW_CYC),
        .LOWEND_CYC(LOWEND_CYC), .HIGH_CYC(HIGH_CYC), .TAIL_CYC(TAIL_CYC),
        .STORE_CYC(STORE_CYC), .NOSTORE_CYC(NOSTORE_CYC), .REARM_CYC(REARM_CYC)
    ) i_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_steps(cmd_steps),
        .cmd_store(cmd_store), .t_done(t_done), .rem_zero(rem_zero),
        .rem_one(rem_one), .cmd_ready(cmd_ready), .pins(pins), .t_load(t_load),
        .t_val(t_val), .s_load(s_load), .s_dec(s_dec)
    );

    pot_seq_timer #(.W(TMR_W)) i_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    pot_seq_steps #(.STEP_W(STEP_W)) i_steps (
        .clk(clk), .rst(rst), .load(s_load), .steps(cmd_steps), .dec(s_dec),
        .rem_zero(rem_zero), .rem_one(rem_one)
    );

    assign pot_cs_n  = pins.cs_n;
    assign pot_ud    = pins.ud;
    assign pot_inc_n = pins.inc_n;
endmodule

// File: rtl/pot_step_seq_chk.sv
module pot_step_seq_chk #(
    parameter int LOW_CYC = 1
) (
    input logic clk,
    input logic rst,
    input logic cmd_ready,
    input logic pot_cs_n,
    input logic pot_ud,
    input logic pot_inc_n
);
    int unsigned low_run;

    always_ff @(posedge clk) begin
        if (rst || pot_inc_n)
            low_run <= 0;
        else if (low_run != 32'hFFFF_FFFF)
            low_run <= low_run + 1;
    end

    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> (pot_cs_n && pot_inc_n));

    a_r2_busy_when_selected: assert property (@(posedge clk) disable iff (rst)
        !pot_cs_n |-> !cmd_ready);

    a_r5_fall_only_selected: assert property (@(posedge clk) disable iff (rst)
        $fell(pot_inc_n) |-> (!pot_cs_n && $past(!pot_cs_n)));

    a_r5_low_width: assert property (@(posedge clk) disable iff (rst)
        $rose(pot_inc_n) |-> (low_run >= LOW_CYC));

    a_r8_busy_after_deselect: assert property (@(posedge clk) disable iff (rst)
        $rose(pot_cs_n) |=> !cmd_ready);

    a_r10_ud_quiet: assert property (@(posedge clk) disable iff (rst)
        (pot_ud != $past(pot_ud)) |-> ($past(pot_cs_n) && $past(pot_inc_n)));
endmodule

bind pot_step_seq pot_step_seq_chk #(.LOW_CYC(LOW_CYC)) i_chk (
    .clk(clk), .rst(rst), .cmd_ready(cmd_ready), .pot_cs_n(pot_cs_n),
    .pot_ud(pot_ud), .pot_inc_n(pot_inc_n)
);

// File: tb/test_pot_step_seq.sv
module test_pot_step_seq;
    localparam int  STEP_W   = 6;
    localparam int  CLK_PS   = 10000;
    localparam int  STORE_NS = 20000;
    localparam int  TAPS     = 32;

    function automatic longint cyc_of(input longint ns);
        longint c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic longint mx(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    // Expected phase lengths derived from the requirement texts.
    localparam longint S  = 290;  // max(100 ns, 2900 ns)
    localparam longint L  = 100;
    localparam longint H  = 100;  // max(1000, 2000-1000) ns
    localparam longint LE = 100;  // max(low, strobe-to-deselect)
    localparam longint T  = 100;  // max(strobe-to-deselect, high)
    localparam longint HS = 2000; // 20 us at 10 ns
    localparam longint NS = 10;
    localparam longint RE = 10;
    localparam longint UDS = 290;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_valid = 1'b0, cmd_store = 1'b0;
    logic [STEP_W-1:0] cmd_steps = '0;
    logic cmd_ready, pot_cs_n, pot_ud, pot_inc_n;

    always #5 clk = ~clk;

    pot_step_seq #(.CLK_PS(CLK_PS), .STEP_W(STEP_W), .STORE_NS(STORE_NS)) i_pot_step_seq (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_steps(cmd_steps), .cmd_store(cmd_store), .pot_cs_n(pot_cs_n),
        .pot_ud(pot_ud), .pot_inc_n(pot_inc_n)
    );

    int n_chk = 0, n_err = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Monitor and device model
    logic   p_cs = 1'b1, p_inc = 1'b1, p_ud = 1'b1, p_rdy = 1'b1;
    longint t_cs_fall = -1000000, t_cs_rise = -1000000, t_inc_fall = -1000000;
    longint t_inc_rise = -1000000, t_ud = -1000000, t_rdy = 0;
    bit     first_in_sel = 1'b0, last_store = 1'b1;
    int     pos = 0, stored = 0, n_fall = 0, n_store = 0, n_nostore = 0, n_sel = 0;

    always @(negedge clk) begin
        if (rst) begin
            p_cs = pot_cs_n; p_inc = pot_inc_n; p_ud = pot_ud; p_rdy = cmd_ready;
        end else begin
            if (p_cs && !pot_cs_n) begin
                chk(cyc - t_cs_rise >= (last_store ? HS : NS), "R8", "reselect gap",
                    cyc - t_cs_rise, last_store ? HS : NS);
                t_cs_fall = cyc; first_in_sel = 1'b1; n_sel++;
            end
            if (pot_ud != p_ud) begin
                chk(p_cs && p_inc, "R10", "ud changed while active", {p_cs, p_inc}, 3);
                chk(cyc - t_inc_rise >= RE, "R10", "ud hold", cyc - t_inc_rise, RE);
                t_ud = cyc;
            end
            if (p_inc && !pot_inc_n) begin
                chk(!pot_cs_n, "R5", "fall while deselected", pot_cs_n, 0);
                chk(cyc - t_ud >= UDS, "R4", "ud setup", cyc - t_ud, UDS);
                if (first_in_sel)
                    chk(cyc - t_cs_fall == S, "R4", "select to first fall", cyc - t_cs_fall, S);
                else begin
                    chk(cyc - t_inc_rise >= H, "R5", "high width", cyc - t_inc_rise, H);
                    chk(cyc - t_inc_fall >= L + H, "R5", "strobe period", cyc - t_inc_fall, L + H);
                end
                if (pot_ud) pos = (pos < TAPS - 1) ? pos + 1 : pos;
                else        pos = (pos > 0) ? pos - 1 : pos;
                n_fall++; t_inc_fall = cyc; first_in_sel = 1'b0;
            end
            if (!p_inc && pot_inc_n) begin
                if (!pot_cs_n)
                    chk(cyc - t_inc_fall >= L, "R5", "low width", cyc - t_inc_fall, L);
                else
                    chk(cyc - t_cs_rise == NS, "R7", "strobe release after deselect",
                        cyc - t_cs_rise, NS);
                t_inc_rise = cyc;
            end
            if (!p_cs && pot_cs_n) begin
                if (pot_inc_n) begin
                    if (first_in_sel)
                        chk(cyc - t_cs_fall == S + T, "R9", "zero-step deselect",
                            cyc - t_cs_fall, S + T);
                    else
                        chk(cyc - t_inc_rise == T, "R6", "tail to deselect",
                            cyc - t_inc_rise, T);
                    stored = pos; n_store++; last_store = 1'b1;
                end else begin
                    chk(cyc - t_inc_fall == LE, "R7", "last fall to deselect",
                        cyc - t_inc_fall, LE);
                    n_nostore++; last_store = 1'b0;
                end
                t_cs_rise = cyc;
            end
            if (!p_rdy && cmd_ready) begin
                chk(cyc - t_cs_rise == (last_store ? HS : NS + RE), "R8", "ready return",
                    cyc - t_cs_rise, last_store ? HS : NS + RE);
                t_rdy = cyc;
            end
            p_cs = pot_cs_n; p_inc = pot_inc_n; p_ud = pot_ud; p_rdy = cmd_ready;
        end
    end

    task automatic send(input int steps, input bit store, output longint acc);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_steps = STEP_W'(steps); cmd_store = store;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        acc = cyc;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (!cmd_ready) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(pot_cs_n == 1'b1, "R1", "reset select", pot_cs_n, 1);
        chk(pot_inc_n == 1'b1, "R1", "reset strobe", pot_inc_n, 1);
        chk(cmd_ready == 1'b1, "R1", "reset ready", cmd_ready, 1);
    endtask

    task automatic t_up_store();
        longint acc; int f0;
        f0 = n_fall;
        send(5, 1'b1, acc);
        chk(cmd_ready == 1'b0, "R2", "ready after accept", cmd_ready, 0);
        chk(pot_ud == 1'b1, "R3", "ud for +5", pot_ud, 1);
        wait_idle();
        chk(n_fall - f0 == 5, "R3", "falls for +5", n_fall - f0, 5);
        chk(pos == 5, "R3", "position", pos, 5);
        chk(stored == 5, "R6", "stored value", stored, 5);
        chk(t_rdy - acc == S + 5*L + 4*H + T + HS, "R8", "+5 store latency",
            t_rdy - acc, S + 5*L + 4*H + T + HS);
    endtask

    task automatic t_down_nostore();
        longint acc; int f0, ns0;
        f0 = n_fall; ns0 = n_nostore;
        send(-3, 1'b0, acc);
        chk(pot_ud == 1'b0, "R3", "ud for -3", pot_ud, 0);
        wait_idle();
        chk(n_fall - f0 == 3, "R3", "falls for -3", n_fall - f0, 3);
        chk(pos == 2, "R3", "position", pos, 2);
        chk(stored == 5, "R7", "stored untouched", stored, 5);
        chk(n_nostore - ns0 == 1, "R7", "no-store endings", n_nostore - ns0, 1);
        chk(t_rdy - acc == S + 2*L + 2*H + LE + NS + RE, "R8", "-3 latency",
            t_rdy - acc, S + 2*L + 2*H + LE + NS + RE);
    endtask

    task automatic t_most_negative();
        longint acc; int f0;
        f0 = n_fall;
        send(-32, 1'b0, acc);
        wait_idle();
        chk(n_fall - f0 == 32, "R3", "falls for -32", n_fall - f0, 32);
        chk(pos == 0, "R3", "position at bottom", pos, 0);
    endtask

    task automatic t_zero_store();
        longint acc; int f0, s0;
        f0 = n_fall; s0 = n_store;
        send(0, 1'b1, acc);
        wait_idle();
        chk(n_fall == f0, "R9", "no strobe on zero step", n_fall - f0, 0);
        chk(n_store - s0 == 1, "R9", "commit on zero step", n_store - s0, 1);
        chk(stored == 0, "R9", "stored value", stored, 0);
        chk(t_rdy - acc == S + T + HS, "R9", "zero-step latency", t_rdy - acc, S + T + HS);
    endtask

    task automatic t_zero_nostore();
        longint acc; int sel0;
        sel0 = n_sel;
        send(0, 1'b0, acc);
        chk(cmd_ready == 1'b1, "R2", "ready after no-op", cmd_ready, 1);
        repeat (20) @(negedge clk);
        chk(n_sel == sel0, "R2", "no select on no-op", n_sel - sel0, 0);
        chk(pot_cs_n == 1'b1 && pot_inc_n == 1'b1, "R2", "pins idle after no-op",
            {pot_cs_n, pot_inc_n}, 3);
    endtask

    task automatic t_back_to_back();
        longint a1, a2;
        send(2, 1'b1, a1);
        send(1, 1'b0, a2);
        chk(a2 - a1 == S + 2*L + H + T + HS + 1, "R2", "second accept cycle",
            a2 - a1, S + 2*L + H + T + HS + 1);
        wait_idle();
        chk(pos == 3, "R3", "position after pair", pos, 3);
        chk(stored == 2, "R6", "stored after pair", stored, 2);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_up_store();
        t_down_nostore();
        t_most_negative();
        t_zero_store();
        t_zero_nostore();
        t_back_to_back();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R2 watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule